// File: doc/BRIEF.md
# Adaptive Interval Test Sequencer

This block is the control sequencer of an adaptive random test generator. A start pulse launches a run. The sequencer pulses an external pattern generator, then raises a capture strobe for each vector that has been applied. It groups vectors into intervals of a programmable length. At each interval boundary it compares the current fault coverage with a target. If the target is not yet met, it asks an external scorer for one predicted detection-rate score per generation scheme. It then switches the pattern generator to the best-scoring scheme for the next interval.

There are five schemes. Their indices 0 to 4 stand for one-probabilities of 1/4, 3/8, 1/2, 5/8 and 3/4, and index 2 is the balanced scheme. A run also ends when the total number of captured vectors reaches an absolute limit. When a run ends, the block raises a done flag with a reason code, and it holds both until the next start pulse. The scores are plain unsigned fixed-point inputs; how they are computed is outside this block.

Top module: `ats_sequencer`

## Requirements
- R1: After reset, `scheme_o` is 2 (balanced), `done_o` is 0, `reason_o` is 00, `test_count_o` is 0, and no strobe is raised.
- R2: Every `record_o` pulse comes exactly one cycle after a `step_o` pulse. The two are never high together, and each applied vector produces exactly one pulse of each.
- R3: Between a start (or a scheme selection) and the next boundary check, exactly `interval_len_i` vectors are recorded.
- R4: When the recorded count reaches `max_tests_i`, the run ends right after that record with `reason_o` = 10. No further step follows. This limit takes precedence over an interval boundary that falls on the same vector.
- R5: At an interval boundary where `coverage_i >= target_cov_i`, the run ends with `reason_o` = 01 and no selection is requested.
- R6: At a boundary where coverage is short, `eval_req_o` stays high until `scores_valid_i` is seen. While it waits, `scheme_o` does not change, and stepping resumes only after the handshake.
- R7: On the handshake, `scheme_o` becomes the index of the largest score. Scheme i occupies bits [16*i+15 : 16*i] of `scores_i`, and on equal scores the lowest index wins.
- R8: `done_o` and `reason_o` hold until a start pulse. A start clears the test count and returns `scheme_o` to 2.
- R9: `test_count_o` equals the number of `record_o` pulses since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches a run when idle or done |
| interval_len_i | input | 16 | Vectors per interval (at least 1) |
| max_tests_i | input | 20 | Absolute vector limit (at least 1) |
| coverage_i | input | 10 | Current fault coverage |
| target_cov_i | input | 10 | Desired fault coverage |
| scores_i | input | 80 | Five 16-bit unsigned detection-rate scores |
| scores_valid_i | input | 1 | Scores handshake |
| step_o | output | 1 | Pulse: produce next vector |
| record_o | output | 1 | Pulse: capture applied vector |
| eval_req_o | output | 1 | Request for scores |
| scheme_o | output | 3 | Active scheme index |
| test_count_o | output | 20 | Vectors recorded this run |
| done_o | output | 1 | Run finished |
| reason_o | output | 2 | 01 coverage, 10 limit |

## Verification
Directed runs cover four endings. In one, coverage is met at a boundary before the limit. In another, the limit and a boundary fall on the same vector, which shows whether the limit takes precedence. A third uses an interval length of one with coverage never met, which shows that a selection follows every vector. The last has a limit shorter than one interval, which shows that no selection happens. Score sets are drawn as wide random values, as all-equal values, and from a two-bit range full of ties; these separate a true maximum from a lowest-index tie break. Randomly drawn lengths, limits and coverage points, together with random delays before the handshake, check interval counts, scheme stability during the wait, and the final totals and reasons.

// File: rtl/ats_pkg.sv
package ats_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP, ST_RECORD, ST_CHECK, ST_EVAL, ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    END_NONE     = 2'b00,
    END_COVERAGE = 2'b01,
    END_LIMIT    = 2'b10
  } end_cause_t;

  // Count after this record meets or exceeds the limit.
  function automatic logic limit_reached(input logic [31:0] count_before,
                                         input logic [31:0] limit);
    return (count_before + 32'd1) >= limit;
  endfunction

  // Interval position after this record closes the interval.
  function automatic logic interval_closed(input logic [31:0] pos_before,
                                           input logic [31:0] len);
    return (pos_before + 32'd1) >= len;
  endfunction

  function automatic logic coverage_met(input logic [31:0] cov,
                                        input logic [31:0] tgt);
    return cov >= tgt;
  endfunction

endpackage

// File: rtl/ats_run_counters.sv
module ats_run_counters #(
  parameter int IVL_W = 16,
  parameter int TOT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             bump_i,
  input  logic [IVL_W-1:0] ivl_len_i,
  input  logic [TOT_W-1:0] max_i,
  output logic [TOT_W-1:0] tot_o,
  output logic             wrap_o,
  output logic             limit_o
);
  import ats_pkg::*;

  logic [IVL_W-1:0] ivl_q;
  logic [TOT_W-1:0] tot_q;

  assign wrap_o  = bump_i && interval_closed(32'(ivl_q), 32'(ivl_len_i));
  assign limit_o = bump_i && limit_reached(32'(tot_q), 32'(max_i));
  assign tot_o   = tot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      tot_q <= '0;
    end else if (clear_i) begin
      ivl_q <= '0;
      tot_q <= '0;
    end else if (bump_i) begin
      tot_q <= tot_q + 1'b1;
      ivl_q <= wrap_o ? '0 : ivl_q + 1'b1;
    end
  end

  // R9: the total only moves on a record or a clear
  assert_count_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !bump_i) |=> $stable(tot_q));

endmodule

// File: rtl/ats_score_pick.sv
module ats_score_pick #(
  parameter int NSCH    = 5,
  parameter int SCORE_W = 16,
  localparam int SCH_W  = $clog2(NSCH)
) (
  input  logic [NSCH*SCORE_W-1:0] scores_i,
  output logic [SCH_W-1:0]        best_o
);

  logic [SCORE_W-1:0] sc [NSCH];

  genvar g;
  generate
    for (g = 0; g < NSCH; g++) begin : g_unpack
      assign sc[g] = scores_i[g*SCORE_W +: SCORE_W];
    end
  endgenerate

  always_comb begin
    int lead;
    lead = 0;
    for (int i = 1; i < NSCH; i++) begin
      if (sc[i] > sc[lead]) lead = i;
    end
    best_o = SCH_W'(lead);
  end

  generate
    for (g = 0; g < NSCH; g++) begin : g_chk
      always_comb begin
        // R7: the chosen score is not beaten, and no earlier index ties it
        assert_pick_max_R7: assert (sc[best_o] >= sc[g]);
        if (g < int'(best_o))
          assert_pick_tie_R7: assert (sc[g] < sc[best_o]);
      end
    end
  endgenerate

endmodule

// File: rtl/ats_sequencer.sv
module ats_sequencer #(
  parameter int NSCH     = 5,
  parameter int SCORE_W  = 16,
  parameter int IVL_W    = 16,
  parameter int TOT_W    = 20,
  parameter int COV_W    = 10,
  parameter int BALANCED = 2,
  localparam int SCH_W   = $clog2(NSCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [IVL_W-1:0]        interval_len_i,
  input  logic [TOT_W-1:0]        max_tests_i,
  input  logic [COV_W-1:0]        coverage_i,
  input  logic [COV_W-1:0]        target_cov_i,
  input  logic [NSCH*SCORE_W-1:0] scores_i,
  input  logic                    scores_valid_i,
  output logic                    step_o,
  output logic                    record_o,
  output logic                    eval_req_o,
  output logic [SCH_W-1:0]        scheme_o,
  output logic [TOT_W-1:0]        test_count_o,
  output logic                    done_o,
  output logic [1:0]              reason_o
);
  import ats_pkg::*;

  seq_state_t       state_q;
  logic [SCH_W-1:0] scheme_q;
  logic             done_q;
  end_cause_t       reason_q;

  // Named internal events
  logic             launch;
  logic             boundary_hit;
  logic             limit_hit;
  logic             cov_ok;
  logic             take_scores;
  logic [SCH_W-1:0] best_idx;

  assign launch      = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign cov_ok      = coverage_met(32'(coverage_i), 32'(target_cov_i));
  assign take_scores = (state_q == ST_EVAL) && scores_valid_i;

  assign step_o     = (state_q == ST_STEP);
  assign record_o   = (state_q == ST_RECORD);
  assign eval_req_o = (state_q == ST_EVAL);
  assign scheme_o   = scheme_q;
  assign done_o     = done_q;
  assign reason_o   = reason_q;

  ats_run_counters #(.IVL_W(IVL_W), .TOT_W(TOT_W)) u_counters (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (launch),
    .bump_i    (record_o),
    .ivl_len_i (interval_len_i),
    .max_i     (max_tests_i),
    .tot_o     (test_count_o),
    .wrap_o    (boundary_hit),
    .limit_o   (limit_hit)
  );

  ats_score_pick #(.NSCH(NSCH), .SCORE_W(SCORE_W)) u_pick (
    .scores_i (scores_i),
    .best_o   (best_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      scheme_q <= SCH_W'(BALANCED);
      done_q   <= 1'b0;
      reason_q <= END_NONE;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            state_q  <= ST_STEP;
            scheme_q <= SCH_W'(BALANCED);
            done_q   <= 1'b0;
            reason_q <= END_NONE;
          end
        end
        ST_STEP: state_q <= ST_RECORD;
        ST_RECORD: begin
          if (limit_hit) begin
            state_q  <= ST_DONE;
            done_q   <= 1'b1;
            reason_q <= END_LIMIT;
          end else if (boundary_hit) begin
            state_q <= ST_CHECK;
          end else begin
            state_q <= ST_STEP;
          end
        end
        ST_CHECK: begin
          if (cov_ok) begin
            state_q  <= ST_DONE;
            done_q   <= 1'b1;
            reason_q <= END_COVERAGE;
          end else begin
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (take_scores) begin
            scheme_q <= best_idx;
            state_q  <= ST_STEP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: capture follows generation by one cycle, never together
  assert_rec_after_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    record_o |-> $past(step_o));
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(record_o && step_o));
  // R4: never record beyond the limit
  assert_under_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    record_o |-> (test_count_o < max_tests_i));
  // R4/R5: a finished run carries one of the two legal reasons
  assert_reason_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (reason_o == 2'b01 || reason_o == 2'b10));
  // R8: done holds until a start
  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(reason_o)));
  // R6: scheme only moves on a handshake or a launch
  assert_scheme_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(eval_req_o && scores_valid_i) && !start_i) |=> $stable(scheme_o));
  // R6: request stays up until answered
  assert_req_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req_o && !scores_valid_i) |=> eval_req_o);

endmodule

// File: tb/ats_sequencer_bench.sv
module ats_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSCH = 5;
  localparam int SW   = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [15:0]       interval_len_i = 16'd1;
  logic [19:0]       max_tests_i = 20'd1;
  logic [9:0]        coverage_i = 10'd0;
  logic [9:0]        target_cov_i = 10'd500;
  logic [NSCH*SW-1:0] scores_i = '0;
  logic              scores_valid_i = 1'b0;
  logic              step_o, record_o, eval_req_o, done_o;
  logic [2:0]        scheme_o;
  logic [19:0]       test_count_o;
  logic [1:0]        reason_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ats_sequencer u_ats_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .interval_len_i(interval_len_i), .max_tests_i(max_tests_i),
    .coverage_i(coverage_i), .target_cov_i(target_cov_i),
    .scores_i(scores_i), .scores_valid_i(scores_valid_i),
    .step_o(step_o), .record_o(record_o), .eval_req_o(eval_req_o),
    .scheme_o(scheme_o), .test_count_o(test_count_o),
    .done_o(done_o), .reason_o(reason_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Highest value first, then the first position holding it.
  function automatic int best_of(input logic [NSCH*SW-1:0] s);
    int top = 0;
    for (int i = 0; i < NSCH; i++)
      if (int'(s[i*SW +: SW]) > top) top = int'(s[i*SW +: SW]);
    for (int i = 0; i < NSCH; i++)
      if (int'(s[i*SW +: SW]) == top) return i;
    return 0;
  endfunction

  function automatic int exp_evals(input int n, input int mx, input int k);
    int c = 0;
    for (int j = 1; j * n < mx; j++)
      if (k == 0 || j < k) c++;
    return c;
  endfunction

  function automatic logic [NSCH*SW-1:0] make_scores(input int mode);
    logic [NSCH*SW-1:0] s;
    int same = $urandom % 65536;
    for (int i = 0; i < NSCH; i++) begin
      if (mode == 0) s[i*SW +: SW] = SW'($urandom % 65536);
      else if (mode == 1) s[i*SW +: SW] = SW'(same);
      else s[i*SW +: SW] = SW'($urandom % 4);
    end
    return s;
  endfunction

  // k: interval after which coverage is met (0 = never)
  task automatic run(input int n, input int mx, input int k, input int mode);
    int recs = 0, steps = 0, ivl = 0, evals = 0, guard = 0;
    int wait_left = 0, exp_sch = 0;
    bit prev_step = 0, answered = 0, pending = 0, first = 1;
    int exp_total, exp_reason;
    interval_len_i = 16'(n);
    max_tests_i    = 20'(mx);
    coverage_i     = 10'd0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_left = $urandom % 4;
    while (!done_o && guard < 5000) begin
      guard++;
      if (first) begin
        chk(step_o == 1'b1, "R8 step after start", int'(step_o), 1);
        chk(scheme_o == 3'd2, "R8 scheme balanced on start", int'(scheme_o), 2);
        first = 0;
      end
      if (pending) begin
        chk(int'(scheme_o) == exp_sch, "R7 scheme after selection", int'(scheme_o), exp_sch);
        scores_valid_i = 1'b0;
        pending = 0;
        answered = 0;
        ivl = 0;
        wait_left = $urandom % 4;
      end
      if (step_o) steps++;
      if (record_o) begin
        if (!prev_step) chk(0, "R2 record without step", 0, 1);
        recs++;
        ivl++;
        if (k > 0 && recs == k * n) coverage_i = target_cov_i;
      end
      if (eval_req_o && !answered) begin
        if (wait_left > 0) begin
          wait_left--;
        end else begin
          chk(ivl == n, "R3 records per interval", ivl, n);
          evals++;
          scores_i = make_scores(mode);
          exp_sch = best_of(scores_i);
          scores_valid_i = 1'b1;
          answered = 1;
          pending = 1;
        end
      end
      prev_step = step_o;
      @(negedge clk);
    end
    exp_total  = (k > 0 && k * n < mx) ? k * n : mx;
    exp_reason = (k > 0 && k * n < mx) ? 1 : 2;
    chk(done_o == 1'b1, "R4/R5 run finished", int'(done_o), 1);
    chk(recs == exp_total, "R4/R5 records in run", recs, exp_total);
    chk(int'(reason_o) == exp_reason, exp_reason == 1 ? "R5 reason" : "R4 reason",
        int'(reason_o), exp_reason);
    chk(int'(test_count_o) == recs, "R9 count matches records", int'(test_count_o), recs);
    chk(evals == exp_evals(n, mx, k), "R6 selections requested", evals, exp_evals(n, mx, k));
    chk(steps == recs, "R2 one record per step", steps, recs);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(done_o && !step_o && int'(reason_o) == exp_reason, "R8 done held, no step",
          int'(step_o), 0);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scheme_o == 3'd2, "R1 reset scheme", int'(scheme_o), 2);
    chk(!done_o && reason_o == 2'b00, "R1 reset done/reason", int'(reason_o), 0);
    chk(test_count_o == 0, "R1 reset count", int'(test_count_o), 0);
    chk(!step_o && !record_o && !eval_req_o, "R1 reset strobes", int'(step_o), 0);
    run(3, 10, 2, 0);   // coverage met at 6
    run(4, 8, 2, 0);    // limit and boundary coincide: limit wins
    run(1, 5, 0, 0);    // select after every vector
    run(5, 3, 0, 0);    // limit inside first interval
    run(2, 12, 0, 1);   // all-equal scores: index 0
    run(2, 14, 0, 2);   // many ties
    for (int r = 0; r < 12; r++)
      run(1 + $urandom % 8, 1 + $urandom % 40, $urandom % 7, $urandom % 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule